// File: doc/BRIEF.md
# Paired-Page Variable-Size Translation Buffer

This block is a fully associative address translation buffer for a processor memory unit. Each entry describes two neighbouring virtual pages, one even and one odd. The pair shares a single virtual tag, an address-space ID and a page-size mask. Each half of the pair has its own physical frame number and its own dirty, valid and global bits. Every entry chooses its own page size, from 4 kB up to 16 MB in factor-of-four steps. The tag compare skips the low bits that the mask covers, so an entry's virtual tag is aligned to twice its page size.

There are two request paths. The lookup path takes a virtual address and the current address-space ID, and one cycle later returns hit, page-valid, dirty and the physical address. The command path carries the five management operations: probe by tag, read by index, write by index, write at a replacement index, and set the wired boundary. Entries below the wired boundary are never chosen as a replacement victim. The replacement index counts down from the top entry to the wired value and then wraps back to the top.

Top module: `ptlb_top`

## Requirements
- R1: Reset leaves every entry empty, sets the wired boundary to 0 and sets the replacement index to N_ENTRIES-1. After reset, lookups and probes miss, a read of any entry returns all-zero fields, and `lk_rsp`, `cmd_rsp` and `lk_hit` are 0.
- R2: A lookup whose `lk_req` is sampled high produces `lk_rsp` high in the following cycle. A lookup hits when the stored tag equals `lk_vaddr[31:13]` on every bit the mask does not cover, and the stored ID equals `cur_asid`.
- R3: The mask encodes the page size as follows: 0x000 for 4 kB, 0x003 for 16 kB, 0x00F for 64 kB, 0x03F for 256 kB, 0x0FF for 1 MB, 0x3FF for 4 MB and 0xFFF for 16 MB. Mask bit j removes virtual address bit 13+j from the tag compare.
- R4: The virtual address bit at position 12 + (number of set mask bits) selects the odd half when it is 1 and the even half when it is 0. On a hit, `lk_paddr` is the selected frame number shifted left by 12, with its low 12+ones(mask) bits replaced by the same bits of `lk_vaddr`.
- R5: Flag bits are packed as {dirty, valid, global}, with dirty at bit 2 and global at bit 0. `lk_pg_valid` and `lk_pg_dirty` come from the selected half. A hit on a half whose valid bit is clear gives `lk_hit`=1 and `lk_pg_valid`=0. A miss returns 0 on `lk_pg_valid`, `lk_pg_dirty` and `lk_paddr`.
- R6: The ID compare is skipped only when the global bits of both halves are set. If only one half is global, the ID must still match.
- R7: A probe (`cmd_op`=1) compares `cmd_vpn2` and `cmd_asid` by the rules of R2, R3 and R6. One cycle later it returns `probe_miss`=0 and the index in `probe_index`, or `probe_miss`=1 if nothing matches.
- R8: A read (`cmd_op`=2) returns the stored tag, ID, mask, both frame numbers and both flag sets of entry `cmd_index` on the `rd_*` outputs, one cycle later.
- R9: An indexed write (`cmd_op`=3) stores all command fields in entry `cmd_index`. An index of N_ENTRIES or above changes no entry.
- R10: A replacement write (`cmd_op`=4) stores into the entry at the replacement index. The index then steps down by one, or wraps to N_ENTRIES-1 if it was already at or below the wired boundary.
- R11: Setting the wired boundary (`cmd_op`=5) loads `cmd_index` as the new boundary and reloads the replacement index to N_ENTRIES-1. A boundary above N_ENTRIES-1 sends every replacement write to entry N_ENTRIES-1.
- R12: When several entries match, lookup and probe both use the lowest-numbered one.
- R13: Every command raises `cmd_rsp` in the following cycle. Operation code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| cur_asid | input | 8 | Current address-space ID |
| lk_rsp | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Tag and ID matched |
| lk_pg_valid | output | 1 | Selected half is valid |
| lk_pg_dirty | output | 1 | Selected half is dirty |
| lk_paddr | output | 32 | Translated physical address |
| cmd_req | input | 1 | Management command request |
| cmd_op | input | 3 | Operation: 0 none, 1 probe, 2 read, 3 indexed write, 4 replacement write, 5 set wired |
| cmd_index | input | 6 | Entry index, or new wired boundary |
| cmd_vpn2 | input | 19 | Virtual tag (address bits 31:13) |
| cmd_asid | input | 8 | Address-space ID |
| cmd_mask | input | 12 | Page-size mask |
| cmd_pfn_even | input | 20 | Even-half frame number |
| cmd_flags_even | input | 3 | Even-half {dirty, valid, global} |
| cmd_pfn_odd | input | 20 | Odd-half frame number |
| cmd_flags_odd | input | 3 | Odd-half {dirty, valid, global} |
| cmd_rsp | output | 1 | Command completed |
| probe_miss | output | 1 | Probe found no entry |
| probe_index | output | 6 | Index found by probe |
| rd_vpn2 | output | 19 | Read tag |
| rd_asid | output | 8 | Read ID |
| rd_mask | output | 12 | Read mask |
| rd_pfn_even | output | 20 | Read even frame number |
| rd_flags_even | output | 3 | Read even flags |
| rd_pfn_odd | output | 20 | Read odd frame number |
| rd_flags_odd | output | 3 | Read odd flags |

## Verification
Assertions check the following on every cycle:
- the one-cycle lookup response;
- that a miss never reports a valid page or an address;
- that the replacement index stays between the wired boundary and the top entry, and steps down by exactly one;
- that setting the boundary reloads the index;
- that an indexed write lands in the named entry;
- that a probe hit points at a filled entry.

Only the bench scenarios can show the rest, by comparing against an independent model of the table:
- the mask-dependent tag compare and even/odd selection for each page size;
- the offset pass-through in the physical address;
- the both-halves-global rule;
- the lowest-index priority;
- the exact victim sequence across changes of the wired boundary.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int VA_W     = 32;
    localparam int BASE_OFS = 12;
    localparam int MASK_W   = 12;
    localparam int ASID_W   = 8;
    localparam int PFN_W    = 20;
    localparam int FLAG_W   = 3;
    localparam int PA_W     = PFN_W + BASE_OFS;
    localparam int VPN2_W   = VA_W - BASE_OFS - 1;
    localparam int OFS_MAX  = BASE_OFS + MASK_W;

    // One half of a page pair.
    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             dirty;
        logic             valid;
        logic             glob;
    } side_t;

    typedef struct packed {
        logic              present;
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic [MASK_W-1:0] mask;
        side_t             even;
        side_t             odd;
    } entry_t;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_PROBE     = 3'd1,
        OP_READ      = 3'd2,
        OP_WR_IDX    = 3'd3,
        OP_WR_RND    = 3'd4,
        OP_SET_WIRED = 3'd5
    } op_e;

    // Bits of the virtual address that pass straight through to the
    // physical address for a given size mask.
    function automatic logic [VA_W-1:0] offset_mask(input logic [MASK_W-1:0] m);
        offset_mask = {{(VA_W-OFS_MAX){1'b0}}, m, {BASE_OFS{1'b1}}};
    endfunction

    // For a well-formed mask, offset_mask + 1 is a single bit: the one
    // just above the page offset, which picks the odd half.
    function automatic logic odd_select(input logic [VA_W-1:0] va,
                                        input logic [MASK_W-1:0] m);
        odd_select = |(va & (offset_mask(m) + VA_W'(1)));
    endfunction

    function automatic side_t pack_side(input logic [PFN_W-1:0] pfn,
                                        input logic [FLAG_W-1:0] fl);
        pack_side.pfn   = pfn;
        pack_side.dirty = fl[2];
        pack_side.valid = fl[1];
        pack_side.glob  = fl[0];
    endfunction
endpackage

// File: rtl/ptlb_match.sv
module ptlb_match
    import ptlb_pkg::*;
(
    input  entry_t            ent,
    input  logic [VPN2_W-1:0] lk_vpn2,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VPN2_W-1:0] pr_vpn2,
    input  logic [ASID_W-1:0] pr_asid,
    output logic              lk_match,
    output logic              pr_match
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [VPN2_W-1:0] care;
    logic              shared;

    assign care   = ~VPN2_W'(ent.mask);
    assign shared = ent.even.glob & ent.odd.glob;

    assign lk_match = ent.present
                   && (((ent.vpn2 ^ lk_vpn2) & care) == '0)
                   && (shared || (ent.asid == lk_asid));
    assign pr_match = ent.present
                   && (((ent.vpn2 ^ pr_vpn2) & care) == '0)
                   && (shared || (ent.asid == pr_asid));
endmodule

// File: rtl/ptlb_first.sv
module ptlb_first #(
    parameter int N     = 48,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    timeunit 1ns;
    timeprecision 1ps;

    // Scan from the top down, so the lowest set bit is assigned last.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/ptlb_victim.sv
module ptlb_victim #(
    parameter int N     = 48,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_wired,
    input  logic [IDX_W-1:0] wired_in,
    input  logic             step,
    output logic [IDX_W-1:0] victim
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [IDX_W-1:0] TOP = IDX_W'(N - 1);

    logic [IDX_W-1:0] wired_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wired_q <= '0;
            victim  <= TOP;
        end else if (set_wired) begin
            wired_q <= wired_in;
            victim  <= TOP;
        end else if (step) begin
            victim <= (victim <= wired_q) ? TOP : victim - 1'b1;
        end
    end

    a_r10_victim_bounds: assert property (@(posedge clk) disable iff (rst)
        (victim <= TOP) && ((victim >= wired_q) || (victim == TOP)));

    a_r10_victim_step: assert property (@(posedge clk) disable iff (rst)
        (step && !set_wired && (victim > wired_q)) |=> (victim == $past(victim) - 1'b1));

    a_r11_wired_reload: assert property (@(posedge clk) disable iff (rst)
        set_wired |=> (victim == TOP));
endmodule

// File: rtl/ptlb_top.sv
module ptlb_top
    import ptlb_pkg::*;
#(
    parameter int N_ENTRIES = 48,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] cur_asid,
    output logic              lk_rsp,
    output logic              lk_hit,
    output logic              lk_pg_valid,
    output logic              lk_pg_dirty,
    output logic [PA_W-1:0]   lk_paddr,
    input  logic              cmd_req,
    input  logic [2:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [VPN2_W-1:0] cmd_vpn2,
    input  logic [ASID_W-1:0] cmd_asid,
    input  logic [MASK_W-1:0] cmd_mask,
    input  logic [PFN_W-1:0]  cmd_pfn_even,
    input  logic [FLAG_W-1:0] cmd_flags_even,
    input  logic [PFN_W-1:0]  cmd_pfn_odd,
    input  logic [FLAG_W-1:0] cmd_flags_odd,
    output logic              cmd_rsp,
    output logic              probe_miss,
    output logic [IDX_W-1:0]  probe_index,
    output logic [VPN2_W-1:0] rd_vpn2,
    output logic [ASID_W-1:0] rd_asid,
    output logic [MASK_W-1:0] rd_mask,
    output logic [PFN_W-1:0]  rd_pfn_even,
    output logic [FLAG_W-1:0] rd_flags_even,
    output logic [PFN_W-1:0]  rd_pfn_odd,
    output logic [FLAG_W-1:0] rd_flags_odd
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [IDX_W:0] N_LIMIT = (IDX_W+1)'(N_ENTRIES);

    op_e op;
    assign op = cmd_req ? op_e'(cmd_op) : OP_NOP;

    entry_t                 tbl [N_ENTRIES];
    logic [N_ENTRIES-1:0]   lk_hits;
    logic [N_ENTRIES-1:0]   pr_hits;
    logic                   lk_any;
    logic                   pr_any;
    logic [IDX_W-1:0]       lk_sel;
    logic [IDX_W-1:0]       pr_sel;
    logic [IDX_W-1:0]       victim;
    logic [VPN2_W-1:0]      lk_vpn2;
    logic                   idx_ok;

    assign lk_vpn2 = lk_vaddr[VA_W-1 -: VPN2_W];
    assign idx_ok  = ({1'b0, cmd_index} < N_LIMIT);

    // Per-entry comparators, one lookup port and one probe port each.
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        ptlb_match u_match (
            .ent      (tbl[g]),
            .lk_vpn2  (lk_vpn2),
            .lk_asid  (cur_asid),
            .pr_vpn2  (cmd_vpn2),
            .pr_asid  (cmd_asid),
            .lk_match (lk_hits[g]),
            .pr_match (pr_hits[g])
        );
    end

    ptlb_first #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_lk_first (
        .req (lk_hits),
        .any (lk_any),
        .idx (lk_sel)
    );

    ptlb_first #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_pr_first (
        .req (pr_hits),
        .any (pr_any),
        .idx (pr_sel)
    );

    ptlb_victim #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .set_wired (op == OP_SET_WIRED),
        .wired_in  (cmd_index),
        .step      (op == OP_WR_RND),
        .victim    (victim)
    );

    // Entry update.
    entry_t           new_ent;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;

    always_comb begin
        new_ent.present = 1'b1;
        new_ent.vpn2    = cmd_vpn2;
        new_ent.asid    = cmd_asid;
        new_ent.mask    = cmd_mask;
        new_ent.even    = pack_side(cmd_pfn_even, cmd_flags_even);
        new_ent.odd     = pack_side(cmd_pfn_odd, cmd_flags_odd);
        wr_en  = 1'b0;
        wr_idx = cmd_index;
        if (op == OP_WR_IDX) begin
            wr_en = idx_ok;
        end else if (op == OP_WR_RND) begin
            wr_en  = 1'b1;
            wr_idx = victim;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENTRIES; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_idx] <= new_ent;
        end
    end

    // Lookup datapath.
    entry_t          lk_ent;
    side_t           lk_side;
    logic [VA_W-1:0] lk_om;
    logic [PA_W-1:0] lk_phys;

    assign lk_ent  = tbl[lk_sel];
    assign lk_side = odd_select(lk_vaddr, lk_ent.mask) ? lk_ent.odd : lk_ent.even;
    assign lk_om   = offset_mask(lk_ent.mask);
    assign lk_phys = ({lk_side.pfn, {BASE_OFS{1'b0}}} & ~PA_W'(lk_om))
                   | PA_W'(lk_vaddr & lk_om);

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_rsp      <= 1'b0;
            lk_hit      <= 1'b0;
            lk_pg_valid <= 1'b0;
            lk_pg_dirty <= 1'b0;
            lk_paddr    <= '0;
        end else begin
            lk_rsp <= lk_req;
            if (lk_req) begin
                lk_hit      <= lk_any;
                lk_pg_valid <= lk_any & lk_side.valid;
                lk_pg_dirty <= lk_any & lk_side.dirty;
                lk_paddr    <= lk_any ? lk_phys : '0;
            end
        end
    end

    // Command responses.
    entry_t rd_ent;
    assign rd_ent = idx_ok ? tbl[cmd_index] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_rsp       <= 1'b0;
            probe_miss    <= 1'b0;
            probe_index   <= '0;
            rd_vpn2       <= '0;
            rd_asid       <= '0;
            rd_mask       <= '0;
            rd_pfn_even   <= '0;
            rd_flags_even <= '0;
            rd_pfn_odd    <= '0;
            rd_flags_odd  <= '0;
        end else begin
            cmd_rsp <= cmd_req;
            if (op == OP_PROBE) begin
                probe_miss  <= ~pr_any;
                probe_index <= pr_sel;
            end
            if (op == OP_READ) begin
                rd_vpn2       <= rd_ent.vpn2;
                rd_asid       <= rd_ent.asid;
                rd_mask       <= rd_ent.mask;
                rd_pfn_even   <= rd_ent.even.pfn;
                rd_flags_even <= {rd_ent.even.dirty, rd_ent.even.valid, rd_ent.even.glob};
                rd_pfn_odd    <= rd_ent.odd.pfn;
                rd_flags_odd  <= {rd_ent.odd.dirty, rd_ent.odd.valid, rd_ent.odd.glob};
            end
        end
    end

    a_r2_lookup_latency: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> lk_rsp);

    a_r5_miss_is_quiet: assert property (@(posedge clk) disable iff (rst)
        (lk_rsp && !lk_hit) |-> (!lk_pg_valid && !lk_pg_dirty && (lk_paddr == '0)));

    a_r7_probe_points_at_entry: assert property (@(posedge clk) disable iff (rst)
        (cmd_rsp && $past(op == OP_PROBE) && !probe_miss) |-> tbl[probe_index].present);

    a_r9_indexed_write_lands: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_WR_IDX) && idx_ok) |=>
            (tbl[$past(cmd_index)].present && (tbl[$past(cmd_index)].vpn2 == $past(cmd_vpn2))));

    a_r13_cmd_ack: assert property (@(posedge clk) disable iff (rst)
        cmd_req |=> cmd_rsp);
endmodule

// File: tb/ptlb_top_tb.sv
module ptlb_top_tb;
    import ptlb_pkg::*;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N  = 48;
    localparam int IW = $clog2(N);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lk_req = 1'b0;
    logic [VA_W-1:0]   lk_vaddr = '0;
    logic [ASID_W-1:0] cur_asid = '0;
    logic              lk_rsp, lk_hit, lk_pg_valid, lk_pg_dirty;
    logic [PA_W-1:0]   lk_paddr;
    logic              cmd_req = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [IW-1:0]     cmd_index = '0;
    logic [VPN2_W-1:0] cmd_vpn2 = '0;
    logic [ASID_W-1:0] cmd_asid = '0;
    logic [MASK_W-1:0] cmd_mask = '0;
    logic [PFN_W-1:0]  cmd_pfn_even = '0, cmd_pfn_odd = '0;
    logic [FLAG_W-1:0] cmd_flags_even = '0, cmd_flags_odd = '0;
    logic              cmd_rsp, probe_miss;
    logic [IW-1:0]     probe_index;
    logic [VPN2_W-1:0] rd_vpn2;
    logic [ASID_W-1:0] rd_asid;
    logic [MASK_W-1:0] rd_mask;
    logic [PFN_W-1:0]  rd_pfn_even, rd_pfn_odd;
    logic [FLAG_W-1:0] rd_flags_even, rd_flags_odd;

    always #2 clk = ~clk;   // 4 ns period

    ptlb_top #(.N_ENTRIES(N)) u_dut (.*);

    int checks = 0;
    int fails  = 0;

    // Reference table.
    bit                m_present [N];
    logic [VPN2_W-1:0] m_vpn2    [N];
    logic [ASID_W-1:0] m_asid    [N];
    logic [MASK_W-1:0] m_mask    [N];
    logic [PFN_W-1:0]  m_pfn_e   [N];
    logic [FLAG_W-1:0] m_fl_e    [N];
    logic [PFN_W-1:0]  m_pfn_o   [N];
    logic [FLAG_W-1:0] m_fl_o    [N];
    int                m_rnd   = N - 1;
    int                m_wired = 0;

    typedef struct {
        logic        hit, pgv, dirty;
        logic [31:0] pa;
        string       tag;
    } lexp_t;

    typedef struct {
        int                kind;   // 0 none, 1 probe, 2 read
        logic              miss;
        logic [IW-1:0]     pidx;
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic [MASK_W-1:0] mask;
        logic [PFN_W-1:0]  pe, po;
        logic [FLAG_W-1:0] fe, fo;
        string             tag;
    } cexp_t;

    lexp_t lq[$];
    cexp_t cq[$];

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_match(input int i, input logic [VPN2_W-1:0] v,
                                   input logic [ASID_W-1:0] a);
        logic [VPN2_W-1:0] care;
        care = ~VPN2_W'(m_mask[i]);
        return m_present[i] && (((m_vpn2[i] ^ v) & care) == '0)
            && ((m_fl_e[i][0] && m_fl_o[i][0]) || (m_asid[i] == a));
    endfunction

    task automatic lookup(input logic [31:0] va, input logic [7:0] as, input string tag);
        lexp_t e;
        e.hit = 0; e.pgv = 0; e.dirty = 0; e.pa = '0; e.tag = tag;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_match(i, va[31:13], as)) begin
                int k;
                logic [31:0] base;
                logic [FLAG_W-1:0] fl;
                k = 12 + $countones(m_mask[i]);
                base = va[k] ? {m_pfn_o[i], 12'h000} : {m_pfn_e[i], 12'h000};
                fl   = va[k] ? m_fl_o[i] : m_fl_e[i];
                e.hit   = 1;
                e.pgv   = fl[1];
                e.dirty = fl[2];
                e.pa    = ((base >> k) << k) | (va & ((32'd1 << k) - 32'd1));
            end
        end
        lq.push_back(e);
        lk_req = 1'b1; lk_vaddr = va; cur_asid = as;
        @(posedge clk); #1;
        lk_req = 1'b0;
    endtask

    task automatic cmd(input op_e op, input int idx, input logic [VPN2_W-1:0] v,
                       input logic [7:0] as, input logic [11:0] mk,
                       input logic [19:0] pe, input logic [2:0] fe,
                       input logic [19:0] po, input logic [2:0] fo, input string tag);
        cexp_t e;
        int w;
        e.kind = 0; e.miss = 1; e.pidx = '0; e.tag = tag;
        if (op == OP_PROBE) begin
            e.kind = 1;
            for (int i = N - 1; i >= 0; i--)
                if (m_match(i, v, as)) begin e.miss = 0; e.pidx = IW'(i); end
        end else if (op == OP_READ) begin
            e.kind = 2;
            e.vpn2 = m_vpn2[idx]; e.asid = m_asid[idx]; e.mask = m_mask[idx];
            e.pe = m_pfn_e[idx]; e.fe = m_fl_e[idx]; e.po = m_pfn_o[idx]; e.fo = m_fl_o[idx];
        end
        w = -1;
        if (op == OP_WR_IDX && idx < N) w = idx;
        if (op == OP_WR_RND) begin
            w = m_rnd;
            m_rnd = (m_rnd <= m_wired) ? N - 1 : m_rnd - 1;
        end
        if (op == OP_SET_WIRED) begin m_wired = idx; m_rnd = N - 1; end
        if (w >= 0) begin
            m_present[w] = 1; m_vpn2[w] = v; m_asid[w] = as; m_mask[w] = mk;
            m_pfn_e[w] = pe; m_fl_e[w] = fe; m_pfn_o[w] = po; m_fl_o[w] = fo;
        end
        cq.push_back(e);
        cmd_req = 1'b1; cmd_op = 3'(op); cmd_index = IW'(idx); cmd_vpn2 = v; cmd_asid = as;
        cmd_mask = mk; cmd_pfn_even = pe; cmd_flags_even = fe; cmd_pfn_odd = po; cmd_flags_odd = fo;
        @(posedge clk); #1;
        cmd_req = 1'b0;
    endtask

    task automatic probe(input logic [VPN2_W-1:0] v, input logic [7:0] as, input string tag);
        cmd(OP_PROBE, 0, v, as, '0, '0, '0, '0, '0, tag);
    endtask

    task automatic rd(input int idx, input string tag);
        cmd(OP_READ, idx, '0, '0, '0, '0, '0, '0, '0, tag);
    endtask

    // Monitor: compares responses against the queued expectations.
    always @(negedge clk) begin
        if (!rst) begin
            if (lk_rsp) begin
                if (lq.size() == 0) chk("R2", "unexpected lookup response", 1, 0);
                else begin
                    lexp_t e;
                    e = lq.pop_front();
                    chk(e.tag, "lk_hit", lk_hit, e.hit);
                    chk(e.tag, "lk_pg_valid", lk_pg_valid, e.pgv);
                    chk(e.tag, "lk_pg_dirty", lk_pg_dirty, e.dirty);
                    chk(e.tag, "lk_paddr", lk_paddr, e.pa);
                end
            end
            if (cmd_rsp) begin
                if (cq.size() == 0) chk("R13", "unexpected command response", 1, 0);
                else begin
                    cexp_t e;
                    e = cq.pop_front();
                    if (e.kind == 1) begin
                        chk(e.tag, "probe_miss", probe_miss, e.miss);
                        if (!e.miss) chk(e.tag, "probe_index", probe_index, e.pidx);
                    end else if (e.kind == 2) begin
                        chk(e.tag, "rd_vpn2", rd_vpn2, e.vpn2);
                        chk(e.tag, "rd_asid", rd_asid, e.asid);
                        chk(e.tag, "rd_mask", rd_mask, e.mask);
                        chk(e.tag, "rd_even", {rd_pfn_even, rd_flags_even}, {e.pe, e.fe});
                        chk(e.tag, "rd_odd", {rd_pfn_odd, rd_flags_odd}, {e.po, e.fo});
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_present[i] = 0; m_vpn2[i] = '0; m_asid[i] = '0; m_mask[i] = '0;
            m_pfn_e[i] = '0; m_fl_e[i] = '0; m_pfn_o[i] = '0; m_fl_o[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1", "lk_rsp after reset", lk_rsp, 0);
        chk("R1", "cmd_rsp after reset", cmd_rsp, 0);
        chk("R1", "lk_hit after reset", lk_hit, 0);
        @(posedge clk); #1;

        // R1: empty table
        lookup(32'h0000_0000, 8'h00, "R1");
        probe('0, 8'h00, "R1");
        rd(0, "R1");
        cmd(OP_NOP, 3, 19'h1, 8'h1, '0, 20'h1, 3'b010, 20'h1, 3'b010, "R13");
        lookup(32'h0000_2000, 8'h01, "R13");

        // R2/R4: 4 kB pair in entry 3
        cmd(OP_WR_IDX, 3, 19'h12345, 8'h05, 12'h000, 20'hAAAAA, 3'b110, 20'h55555, 3'b010, "R9");
        lookup({19'h12345, 1'b0, 12'hABC}, 8'h05, "R2");
        lookup({19'h12345, 1'b1, 12'hABC}, 8'h05, "R4");
        lookup({19'h12345, 1'b0, 12'hABC}, 8'h06, "R2");
        lookup({19'h12346, 1'b0, 12'hABC}, 8'h05, "R2");

        // R3/R6: 16 MB global pair in entry 10
        cmd(OP_WR_IDX, 10, 19'h40000, 8'h01, 12'hFFF, 20'h12300, 3'b011, 20'hFF000, 3'b011, "R9");
        lookup(32'h80AB_CDEF, 8'h77, "R3");
        lookup(32'h8100_0010, 8'h22, "R6");
        lookup(32'h8200_0010, 8'h22, "R3");

        // R3/R6: 64 kB pair, only even half global, entry 11
        cmd(OP_WR_IDX, 11, 19'h00100, 8'h09, 12'h00F, 20'h0BEEF, 3'b011, 20'h0CAFE, 3'b110, "R9");
        lookup(32'h0020_1234, 8'h09, "R3");
        lookup(32'h0021_1234, 8'h09, "R4");
        lookup(32'h0020_E000, 8'h09, "R3");
        lookup(32'h0020_1234, 8'h03, "R6");

        // R5: odd half invalid
        cmd(OP_WR_IDX, 12, 19'h30000, 8'h05, 12'h000, 20'h00042, 3'b010, 20'h00043, 3'b100, "R9");
        lookup(32'h6000_1008, 8'h05, "R5");
        lookup(32'h6000_0008, 8'h05, "R5");

        // R12: duplicate tags in 21 and 20
        cmd(OP_WR_IDX, 21, 19'h0ABCD, 8'h02, 12'h000, 20'h22222, 3'b010, 20'h22223, 3'b010, "R9");
        cmd(OP_WR_IDX, 20, 19'h0ABCD, 8'h02, 12'h000, 20'h11111, 3'b010, 20'h11112, 3'b010, "R9");
        probe(19'h0ABCD, 8'h02, "R12");
        lookup({19'h0ABCD, 1'b0, 12'h123}, 8'h02, "R12");

        // R7: probe hit and miss
        probe(19'h12345, 8'h05, "R7");
        probe(19'h12345, 8'h04, "R7");
        probe(19'h00101, 8'h09, "R7");

        // R8: read back
        rd(11, "R8");
        rd(3, "R8");

        // R9: out-of-range index ignored
        cmd(OP_WR_IDX, 50, 19'h55555, 8'h01, '0, 20'h1, 3'b010, 20'h2, 3'b010, "R9");
        probe(19'h55555, 8'h01, "R9");
        lookup({19'h55555, 1'b0, 12'h000}, 8'h01, "R9");

        // R10: replacement sequence with wired = 0
        cmd(OP_WR_RND, 0, 19'h70001, 8'h01, '0, 20'h70001, 3'b010, 20'h0, 3'b000, "R10");
        cmd(OP_WR_RND, 0, 19'h70002, 8'h01, '0, 20'h70002, 3'b010, 20'h0, 3'b000, "R10");
        probe(19'h70001, 8'h01, "R10");
        probe(19'h70002, 8'h01, "R10");
        rd(N - 2, "R10");

        // R11: wired = 44, then wrap
        cmd(OP_SET_WIRED, 44, '0, '0, '0, '0, '0, '0, '0, "R11");
        for (int j = 0; j < 5; j++)
            cmd(OP_WR_RND, 0, 19'h71000 + 19'(j), 8'h01, '0, 20'h71000 + 20'(j), 3'b010, 20'h0, 3'b000, "R11");
        for (int j = 0; j < 5; j++) probe(19'h71000 + 19'(j), 8'h01, "R11");
        probe(19'h0ABCD, 8'h02, "R11");
        rd(44, "R10");

        // R11: wired above the top pins the victim
        cmd(OP_SET_WIRED, 60, '0, '0, '0, '0, '0, '0, '0, "R11");
        cmd(OP_WR_RND, 0, 19'h72000, 8'h01, '0, 20'h72000, 3'b010, 20'h0, 3'b000, "R11");
        cmd(OP_WR_RND, 0, 19'h72001, 8'h01, '0, 20'h72001, 3'b010, 20'h0, 3'b000, "R11");
        probe(19'h72000, 8'h01, "R11");
        probe(19'h72001, 8'h01, "R11");
        rd(N - 1, "R11");

        repeat (4) @(posedge clk);
        chk("R13", "pending lookups", lq.size(), 0);
        chk("R13", "pending commands", cq.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule